// File: doc/BRIEF.md
# BCD Countdown Timer Core

This block holds a countdown value of eight BCD digits, arranged as four two-digit fields: hours, minutes, seconds and hundredths of a second. It runs on a fast system clock. An internal divider makes a one-cycle tick. Each tick removes one hundredth from the value. A borrow carries upward through the fields in mixed radix: 99 for hundredths and 59 for the other three fields.

A level input chooses between two tick rates. With the default divide values on a 50 MHz clock, the fast rate makes one tick per real hundredth of a second and the slow rate is ten times slower. A reload pulse returns the value to a fixed preset of 00:03:SS:CC, where SS and CC are parameters. A pause input stops counting. A parallel load port lets an external digit editor overwrite all eight digits. The value stops at zero and does not wrap. A finished flag then stays high until the next reload or load.

Display decoding, multiplexing and debouncing of buttons are handled outside this block.

Top module: `bcd_countdown_timer`

## Requirements
- R1: Both the asynchronous reset and a high `reload_i` at a clock edge set `digits_o` to 00:03:SS:CC. SS is `PRESET_SEC` and CC is `PRESET_HUN`. Both clear `done_o`.
- R2: `digits_o[31:24]` holds hours, `[23:16]` minutes, `[15:8]` seconds and `[7:0]` hundredths. In each byte, bits [7:4] are the tens digit and bits [3:0] are the ones digit, both in BCD.
- R3: The value is always legal. For hours, minutes and seconds the tens digit is 0 to 5 and the ones digit is 0 to 9. For hundredths both digits are 0 to 9.
- R4: Each tick lowers the value by one hundredth. A field at 00 that receives a borrow becomes 59, or 99 for hundredths, and passes the borrow to the next field up.
- R5: Ticks occur every `FAST_DIV` clock edges when `slow_i`=0 and every `SLOW_DIV` edges when `slow_i`=1. The interval restarts from the edge that reloads or loads the value.
- R6: While `pause_i` is high the value does not change and the tick interval is frozen. Counting resumes where it stopped.
- R7: When `load_en_i` is high at an edge, `digits_o` takes `load_digits_i`. Any digit above its legal maximum is clamped to that maximum.
- R8: Priority, from highest to lowest: reload, then load, then pause, then counting.
- R9: At 00:00:00:00 the value stays at zero on every later tick.
- R10: `done_o` rises on the edge where a tick brings the value to zero, or on the first tick while the value is already zero. It stays high until a reload or a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; sets the value to the preset |
| reload_i | input | 1 | Synchronous preset reload from the debounced pushbutton |
| slow_i | input | 1 | Rate select: 0 selects the normal rate, 1 selects the slow rate |
| pause_i | input | 1 | Stops counting while high |
| load_en_i | input | 1 | Writes `load_digits_i` into the value |
| load_digits_i | input | 32 | Digits written by a load, using the layout of `digits_o` |
| digits_o | output | 32 | Current value as eight BCD digits, most significant digit first |
| done_o | output | 1 | Finished flag |

## Verification
A wrong borrow decision shows up at the ports on the first tick after a field reaches 00. For example, a load of 01:00:00:00 must read 00:59:59:99 one tick later, so a broken chain appears within a single divide interval. A tick counter that is too fast or too slow misplaces the first step by one or more edges. The bench therefore samples one edge before and one edge after each expected step. A done flag that is not sticky, or a counter that wraps at zero, shows up only after further ticks, so the bench runs idle intervals past zero before it checks.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
  localparam int unsigned FIELDS   = 4;
  localparam int unsigned PAIR_W   = 8;
  localparam int unsigned DIGITS_W = FIELDS * PAIR_W;

  // field 0 is hundredths (radix 100), the rest are radix 60
  function automatic logic [3:0] tens_max(int unsigned idx);
    return (idx == 0) ? 4'd9 : 4'd5;
  endfunction

  function automatic logic [7:0] pair_clamp(logic [7:0] p, logic [3:0] tmax);
    logic [3:0] t;
    logic [3:0] o;
    t = (p[7:4] > tmax) ? tmax : p[7:4];
    o = (p[3:0] > 4'd9) ? 4'd9 : p[3:0];
    return {t, o};
  endfunction

  function automatic logic digits_ok(logic [DIGITS_W-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < FIELDS; i++) begin
      if (d[i*PAIR_W+4 +: 4] > tens_max(i)) ok = 1'b0;
      if (d[i*PAIR_W +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/ctd_tick_gen.sv
module ctd_tick_gen #(
  parameter int unsigned FAST_DIV = 500000,
  parameter int unsigned SLOW_DIV = 5000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hold_i,
  input  logic slow_i,
  output logic tick_o
);
  localparam int unsigned MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int unsigned CW      = $clog2(MAX_DIV + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = slow_i ? CW'(SLOW_DIV) : CW'(FAST_DIV);
  // >= so a rate switch mid-interval never overshoots
  assign tick_o = ~hold_i & (cnt_q >= lim - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (hold_i) cnt_q <= cnt_q;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/ctd_bcd_field.sv
module ctd_bcd_field #(
  parameter logic [3:0] TENS_MAX = 4'd5,
  parameter logic [7:0] PRESET   = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reload_i,
  input  logic       load_en_i,
  input  logic [7:0] load_i,
  input  logic       borrow_i,
  output logic [7:0] val_o,
  output logic       borrow_o
);
  logic [7:0] val_q;
  logic [7:0] val_d;
  logic       is_zero;

  assign is_zero  = (val_q == 8'h00);
  assign borrow_o = borrow_i & is_zero;
  assign val_o    = val_q;

  always_comb begin
    val_d = val_q;
    if (reload_i)                val_d = PRESET;
    else if (load_en_i)          val_d = ctd_pkg::pair_clamp(load_i, TENS_MAX);
    else if (borrow_i) begin
      if (is_zero)               val_d = {TENS_MAX, 4'd9};
      else if (val_q[3:0] == '0) val_d = {val_q[7:4] - 4'd1, 4'd9};
      else                       val_d = {val_q[7:4], val_q[3:0] - 4'd1};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= PRESET;
    else         val_q <= val_d;
  end
endmodule

// File: rtl/bcd_countdown_timer.sv
module bcd_countdown_timer #(
  parameter int unsigned FAST_DIV   = 500000,
  parameter int unsigned SLOW_DIV   = 5000000,
  parameter logic [7:0]  PRESET_SEC = 8'h45,
  parameter logic [7:0]  PRESET_HUN = 8'h67
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reload_i,
  input  logic        slow_i,
  input  logic        pause_i,
  input  logic        load_en_i,
  input  logic [31:0] load_digits_i,
  output logic [31:0] digits_o,
  output logic        done_o
);
  import ctd_pkg::*;

  localparam logic [DIGITS_W-1:0] PRESET_ALL = {8'h00, 8'h03, PRESET_SEC, PRESET_HUN};

  logic              tick;
  logic              all_zero;
  logic              le_one;
  logic [FIELDS:0]   borrow;
  logic              done_q;

  ctd_tick_gen #(
    .FAST_DIV (FAST_DIV),
    .SLOW_DIV (SLOW_DIV)
  ) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (reload_i | load_en_i),
    .hold_i (pause_i),
    .slow_i (slow_i),
    .tick_o (tick)
  );

  assign all_zero  = (digits_o == '0);
  assign le_one    = (digits_o[DIGITS_W-1:PAIR_W] == '0) && (digits_o[PAIR_W-1:0] <= 8'h01);
  assign borrow[0] = tick & ~all_zero;

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    ctd_bcd_field #(
      .TENS_MAX (tens_max(i)),
      .PRESET   (PRESET_ALL[i*PAIR_W +: PAIR_W])
    ) u_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .reload_i  (reload_i),
      .load_en_i (load_en_i),
      .load_i    (load_digits_i[i*PAIR_W +: PAIR_W]),
      .borrow_i  (borrow[i]),
      .val_o     (digits_o[i*PAIR_W +: PAIR_W]),
      .borrow_o  (borrow[i+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   done_q <= 1'b0;
    else if (reload_i | load_en_i) done_q <= 1'b0;
    else if (tick & le_one)        done_q <= 1'b1;
  end

  assign done_o = done_q;
endmodule

// File: rtl/bcd_countdown_timer_chk.sv
module bcd_countdown_timer_chk #(
  parameter logic [7:0] PRESET_SEC = 8'h45,
  parameter logic [7:0] PRESET_HUN = 8'h67
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reload_i,
  input logic        pause_i,
  input logic        load_en_i,
  input logic [31:0] load_digits_i,
  input logic [31:0] digits_o,
  input logic        done_o
);
  localparam logic [31:0] PRESET_ALL = {8'h00, 8'h03, PRESET_SEC, PRESET_HUN};

  AST_RELOAD_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (digits_o == PRESET_ALL) && !done_o); // R1

  AST_DIGITS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctd_pkg::digits_ok(digits_o)); // R3

  AST_LOAD_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i && !reload_i && ctd_pkg::digits_ok(load_digits_i)
    |=> digits_o == $past(load_digits_i)); // R7

  AST_LOAD_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i && !reload_i && (load_digits_i[31:28] > 4'd5)
    |=> digits_o[31:28] == 4'd5); // R7

  AST_PAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i && !reload_i && !load_en_i |=> $stable(digits_o)); // R6

  AST_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digits_o == '0) && !reload_i && !load_en_i |=> digits_o == '0); // R9

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !reload_i && !load_en_i |=> done_o); // R10

  AST_DONE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> digits_o == '0); // R10
endmodule

bind bcd_countdown_timer bcd_countdown_timer_chk #(
  .PRESET_SEC (PRESET_SEC),
  .PRESET_HUN (PRESET_HUN)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reload_i      (reload_i),
  .pause_i       (pause_i),
  .load_en_i     (load_en_i),
  .load_digits_i (load_digits_i),
  .digits_o      (digits_o),
  .done_o        (done_o)
);

// File: tb/bcd_countdown_timer_test.sv
module bcd_countdown_timer_test;
  localparam int FD = 4;
  localparam int SD = 10;
  localparam logic [31:0] PRESET = 32'h0003_4567;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reload_i = 1'b0;
  logic        slow_i = 1'b0;
  logic        pause_i = 1'b0;
  logic        load_en_i = 1'b0;
  logic [31:0] load_digits_i = '0;
  logic [31:0] digits_o;
  logic        done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2 clk_i = ~clk_i;

  bcd_countdown_timer #(
    .FAST_DIV (FD), .SLOW_DIV (SD), .PRESET_SEC (8'h45), .PRESET_HUN (8'h67)
  ) uut (
    .clk_i (clk_i), .rst_ni (rst_ni), .reload_i (reload_i), .slow_i (slow_i),
    .pause_i (pause_i), .load_en_i (load_en_i), .load_digits_i (load_digits_i),
    .digits_o (digits_o), .done_o (done_o)
  );

  function automatic int pair_val(logic [7:0] p);
    return int'(p[7:4]) * 10 + int'(p[3:0]);
  endfunction

  function automatic int to_hun(logic [31:0] d);
    return pair_val(d[31:24]) * 360000 + pair_val(d[23:16]) * 6000
         + pair_val(d[15:8]) * 100 + pair_val(d[7:0]);
  endfunction

  function automatic logic [7:0] to_pair(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [31:0] to_bcd(int t);
    return {to_pair(t / 360000), to_pair((t / 6000) % 60),
            to_pair((t / 100) % 60), to_pair(t % 100)};
  endfunction

  function automatic logic [31:0] exp_val(logic [31:0] v, int steps);
    int n;
    n = to_hun(v) - steps;
    return to_bcd(n < 0 ? 0 : n);
  endfunction

  function automatic logic exp_done(logic [31:0] v, int steps);
    int n;
    n = to_hun(v);
    return steps >= ((n == 0) ? 1 : n);
  endfunction

  task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s digits actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s done actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load(logic [31:0] v);
    load_en_i = 1'b1;
    load_digits_i = v;
    @(posedge clk_i);
    @(negedge clk_i);
    load_en_i = 1'b0;
  endtask

  task automatic run(int k);
    repeat (k) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // one-tick borrow cases, sampled one edge before and at the step (R2 R4 R5)
  task automatic borrow_case(logic [31:0] v);
    load(v);
    run(FD - 1);
    chk32("R5", digits_o, v);
    run(1);
    chk32("R4", digits_o, exp_val(v, 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    int k;
    int div;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk32("R1", digits_o, PRESET);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk32("R1", digits_o, PRESET);
    chk1("R1", done_o, 1'b0);

    borrow_case(32'h0000_0010);
    borrow_case(32'h0000_0100);
    borrow_case(32'h0001_0000);
    borrow_case(32'h0100_0000);
    borrow_case(32'h0159_5900);
    chk32("R2", digits_o, 32'h0159_5899);

    // approach and hold zero (R9 R10)
    load(32'h0000_0002);
    run(FD);
    chk1("R10", done_o, 1'b0);
    run(FD);
    chk32("R9", digits_o, 32'h0);
    chk1("R10", done_o, 1'b1);
    run(5 * FD);
    chk32("R9", digits_o, 32'h0);
    chk1("R10", done_o, 1'b1);

    // loaded zero: done clears, rises on first tick
    load(32'h0);
    chk1("R10", done_o, 1'b0);
    run(FD);
    chk1("R10", done_o, 1'b1);
    reload_i = 1'b1;
    run(1);
    reload_i = 1'b0;
    chk32("R1", digits_o, PRESET);
    chk1("R1", done_o, 1'b0);

    // pause freezes value and interval (R6)
    v = 32'h0012_3456;
    load(v);
    run(5);
    pause_i = 1'b1;
    run(30);
    chk32("R6", digits_o, exp_val(v, 1));
    pause_i = 1'b0;
    run(3);
    chk32("R6", digits_o, exp_val(v, 2));

    // slow rate (R5)
    slow_i = 1'b1;
    load(v);
    run(SD - 1);
    chk32("R5", digits_o, v);
    run(1);
    chk32("R5", digits_o, exp_val(v, 1));
    slow_i = 1'b0;

    // priority (R8)
    pause_i = 1'b1;
    load(32'h0000_1111);
    chk32("R8", digits_o, 32'h0000_1111);
    reload_i = 1'b1;
    load(32'h0000_2222);
    reload_i = 1'b0;
    chk32("R8", digits_o, PRESET);
    pause_i = 1'b0;

    // clamping (R7 R3)
    load(32'hFFFF_FFFF);
    chk32("R7", digits_o, 32'h5959_5999);
    load(32'h6A7B_8C0D);
    chk32("R7", digits_o, 32'h5959_5909);

    // random loads and run lengths (R4 R5 R9 R10)
    for (int it = 0; it < 40; it++) begin
      if ($urandom % 2 == 0) v = to_bcd(int'($urandom % 40));
      else                   v = to_bcd(int'($urandom % (60 * 360000)));
      slow_i = ($urandom % 3 == 0);
      div = slow_i ? SD : FD;
      k = int'($urandom % 120);
      load(v);
      run(k);
      chk32("R4", digits_o, exp_val(v, k / div));
      chk1("R10", done_o, exp_done(v, k / div));
    end
    slow_i = 1'b0;

    finish_up();
  end
endmodule